// File: doc/BRIEF.md
# Dual-Slot Conditional-Access Card Bridge

This block sits between a simple register port and the connectors of two common-interface card slots. Software loads a 14-bit card address through two byte registers. It then uses a bus control register to pick the slot and the access space, which is either attribute memory or control space. An access to the data register launches one byte transfer on the selected slot and returns the byte read. The card side is a strobe handshake: the bridge raises a read or write strobe together with the chip select of the slot, and holds them until the card answers on its ready line or a timeout expires.

The bus control register also holds four kinds of slot state. A per-slot reset request clears itself when a programmable pulse has finished. A per-slot transport-stream path enable drives an output. Two read-only presence bits are active-low, so 0 means a card is present. Any change of presence produces a one-cycle event pulse for the interrupt logic.

Register select encoding on `reg_sel_i`: 0 = address low, 1 = address high, 2 = bus control, 3 = data. A request is a one-cycle `reg_req_i`. `reg_rdata_o` is valid only in the cycle `reg_ack_o` is high. Requests that arrive while a data transfer is in flight are dropped.

Top module: `cam_bridge`

## Requirements
- R1: A write to the address low register puts its bits 7:1 on card address bits 6:0. Its bit 0 is discarded, and a read returns the stored bits in 7:1 with bit 0 as 0.
- R2: A write to the address high register puts its bits 6:0 on card address bits 13:7. Its bit 7 is discarded and reads back as 0.
- R3: During a data transfer only `card_cs_o[s]` is high, where s is bus control bit 7. `card_space_o` equals bus control bit 6 (1 = control space, 0 = attribute memory).
- R4: Writing 1 to bus control bit (5 − s) drives `card_reset_o[s]` high for exactly RST_CYCLES cycles. That bit reads 1 while the pulse runs and 0 afterwards. Writing 0 to it starts nothing, and the other slot is unaffected.
- R5: Bus control bit (3 − s) is stored, drives `ts_en_o[s]` and reads back.
- R6: Bus control bit 1 reads slot 0 presence and bit 0 reads slot 1 presence. Both copy `card_present_ni`, which is active-low, one clock after the input.
- R7: A data-register read raises `card_rd_o` and the selected chip select. It returns `card_rdata_i` from the cycle ready is seen, and is acknowledged 2 cycles after the request when the card is ready at once.
- R8: A data-register write raises `card_wr_o` with `card_wdata_o` equal to the written byte, at the latched card address.
- R9: If ready does not come within TIMEOUT cycles, the strobe drops and the access ends. The acknowledge comes TIMEOUT+1 cycles after the request, and a read returns 0xFF.
- R10: Each change of the registered presence bits gives exactly one one-cycle pulse on `event_o`.
- R11: Accesses to the address and bus control registers are acknowledged 1 cycle after the request.
- R12: After reset, the address, slot, space and path-enable state are 0. No strobe, card reset, event or acknowledge is active, and both presence bits read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | One-cycle register request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 8 | Write byte |
| reg_ack_o | output | 1 | Request completed |
| reg_rdata_o | output | 8 | Read byte, valid with ack |
| card_addr_o | output | 14 | Card address |
| card_cs_o | output | 2 | Per-slot chip select during a transfer |
| card_space_o | output | 1 | 1 = control space, 0 = attribute memory |
| card_rd_o | output | 1 | Read strobe |
| card_wr_o | output | 1 | Write strobe |
| card_wdata_o | output | 8 | Byte driven to the card |
| card_rdata_i | input | 8 | Byte returned by the card |
| card_ready_i | input | 1 | Card completes the strobe |
| card_reset_o | output | 2 | Per-slot card reset pulse |
| ts_en_o | output | 2 | Per-slot stream path enable |
| card_present_ni | input | 2 | Per-slot presence, active low |
| event_o | output | 1 | Presence change pulse |

## Verification
The bench checks the bit-reversed slot order in the reset, path-enable and presence fields. A design that swapped slot and bit would reset, enable or report the wrong slot. It measures the reset pulse length to the cycle, so an off-by-one counter shows up, and so does a bit that stays set or clears early. A card that never answers must end the access after exactly TIMEOUT+1 cycles with 0xFF. A hung or early-ending transfer is caught there. The low-address shift and the discarded top and bottom bits are checked through read-back and through the address seen at the card.

// File: rtl/cam_bridge_pkg.sv
package cam_bridge_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR_LO  = 2'd0,
    SEL_ADDR_HI  = 2'd1,
    SEL_BUS_CTRL = 2'd2,
    SEL_DATA     = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_SLOT_BIT  = 7;
  localparam int unsigned CTRL_SPACE_BIT = 6;
  localparam int unsigned CTRL_RST_TOP   = 5;
  localparam int unsigned CTRL_TS_TOP    = 3;
  localparam int unsigned CTRL_PRES_TOP  = 1;
  localparam logic [7:0]  TIMEOUT_BYTE   = 8'hFF;
endpackage

// File: rtl/cam_reset_gen.sv
module cam_reset_gen #(
  parameter int unsigned CYCLES = 4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= CW'(CYCLES - 1);
      active_q <= 1'b1;
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign active_o = active_q;

  // R4: pulse ends once the count is spent
  a_r4_pulse_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cnt_q == '0 && !start_i) |=> !active_q);
endmodule

// File: rtl/cam_xfer.sv
module cam_xfer #(
  parameter int unsigned TIMEOUT = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rdata_o,
  output logic       rd_o,
  output logic       wr_o,
  output logic [7:0] wdata_o,
  input  logic       ready_i,
  input  logic [7:0] card_rdata_i
);
  import cam_bridge_pkg::*;
  localparam int unsigned CW = $clog2(TIMEOUT + 1);

  logic          busy_q, we_q, done_q;
  logic [7:0]    wd_q, rd_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      we_q   <= 1'b0;
      done_q <= 1'b0;
      wd_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          we_q   <= we_i;
          wd_q   <= wdata_i;
          cnt_q  <= '0;
        end
      end else if (ready_i) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        rd_q   <= we_q ? 8'h00 : card_rdata_i;
      end else if (cnt_q == CW'(TIMEOUT - 1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        rd_q   <= TIMEOUT_BYTE;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign rdata_o = rd_q;
  assign rd_o    = busy_q & ~we_q;
  assign wr_o    = busy_q & we_q;
  assign wdata_o = wd_q;

  // R7
  a_r7_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));
  // R9
  a_r9_wait_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < CW'(TIMEOUT)));
  // R7: strobe held until ready or timeout
  a_r7_strobe_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_o || wr_o) && !ready_i && cnt_q != CW'(TIMEOUT - 1)) |=> (rd_o || wr_o));
endmodule

// File: rtl/cam_bridge.sv
module cam_bridge #(
  parameter int unsigned RST_CYCLES = 4000,
  parameter int unsigned TIMEOUT    = 256
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_req_i,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_sel_i,
  input  logic [7:0]  reg_wdata_i,
  output logic        reg_ack_o,
  output logic [7:0]  reg_rdata_o,
  output logic [13:0] card_addr_o,
  output logic [1:0]  card_cs_o,
  output logic        card_space_o,
  output logic        card_rd_o,
  output logic        card_wr_o,
  output logic [7:0]  card_wdata_o,
  input  logic [7:0]  card_rdata_i,
  input  logic        card_ready_i,
  output logic [1:0]  card_reset_o,
  output logic [1:0]  ts_en_o,
  input  logic [1:0]  card_present_ni,
  output logic        event_o
);
  import cam_bridge_pkg::*;
  localparam int unsigned NSLOT = 2;

  logic [6:0]       addr_lo_q, addr_hi_q;
  logic             slot_q, space_q, ack_q;
  logic [NSLOT-1:0] ts_q, pres_q, pres_prev_q, rst_act, rst_start;
  logic [7:0]       rdata_q, ctrl_rd;
  logic             xfer_busy, xfer_done, strobe;
  logic [7:0]       xfer_rdata;
  logic             fire, fire_wr;
  reg_sel_e         sel;

  assign sel     = reg_sel_e'(reg_sel_i);
  assign fire    = reg_req_i & ~xfer_busy;
  assign fire_wr = fire & reg_we_i;

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTRL_SLOT_BIT]  = slot_q;
    ctrl_rd[CTRL_SPACE_BIT] = space_q;
    for (int s = 0; s < NSLOT; s++) begin
      ctrl_rd[CTRL_RST_TOP - s]  = rst_act[s];
      ctrl_rd[CTRL_TS_TOP - s]   = ts_q[s];
      ctrl_rd[CTRL_PRES_TOP - s] = pres_q[s];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_lo_q   <= '0;
      addr_hi_q   <= '0;
      slot_q      <= 1'b0;
      space_q     <= 1'b0;
      ts_q        <= '0;
      ack_q       <= 1'b0;
      rdata_q     <= '0;
      pres_q      <= '1;
      pres_prev_q <= '1;
    end else begin
      pres_q      <= card_present_ni;
      pres_prev_q <= pres_q;
      ack_q       <= fire && sel != SEL_DATA;
      if (fire && sel != SEL_DATA) begin
        unique case (sel)
          SEL_ADDR_LO: rdata_q <= {addr_lo_q, 1'b0};
          SEL_ADDR_HI: rdata_q <= {1'b0, addr_hi_q};
          default:     rdata_q <= ctrl_rd;
        endcase
      end
      if (fire_wr) begin
        unique case (sel)
          SEL_ADDR_LO: addr_lo_q <= reg_wdata_i[7:1];
          SEL_ADDR_HI: addr_hi_q <= reg_wdata_i[6:0];
          SEL_BUS_CTRL: begin
            slot_q  <= reg_wdata_i[CTRL_SLOT_BIT];
            space_q <= reg_wdata_i[CTRL_SPACE_BIT];
            for (int s = 0; s < NSLOT; s++) ts_q[s] <= reg_wdata_i[CTRL_TS_TOP - s];
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign rst_start[s] = fire_wr && sel == SEL_BUS_CTRL && reg_wdata_i[CTRL_RST_TOP - s];
    cam_reset_gen #(.CYCLES(RST_CYCLES)) u_rst (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (rst_start[s]),
      .active_o (rst_act[s])
    );
    assign card_cs_o[s] = strobe && (slot_q == 1'(s));
  end

  cam_xfer #(.TIMEOUT(TIMEOUT)) u_xfer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (fire && sel == SEL_DATA),
    .we_i         (reg_we_i),
    .wdata_i      (reg_wdata_i),
    .busy_o       (xfer_busy),
    .done_o       (xfer_done),
    .rdata_o      (xfer_rdata),
    .rd_o         (card_rd_o),
    .wr_o         (card_wr_o),
    .wdata_o      (card_wdata_o),
    .ready_i      (card_ready_i),
    .card_rdata_i (card_rdata_i)
  );

  assign strobe       = card_rd_o | card_wr_o;
  assign card_addr_o  = {addr_hi_q, addr_lo_q};
  assign card_space_o = space_q;
  assign card_reset_o = rst_act;
  assign ts_en_o      = ts_q;
  assign event_o      = |(pres_q ^ pres_prev_q);
  assign reg_ack_o    = ack_q | xfer_done;
  assign reg_rdata_o  = xfer_done ? xfer_rdata : rdata_q;

  // R11: register ack and transfer completion never collide
  a_r11_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_q && xfer_done));
  // R5: path enables move only on a bus control write
  a_r5_ts_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fire_wr && sel == SEL_BUS_CTRL) |=> $stable(ts_en_o));
  // R3
  a_r3_cs_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(card_cs_o));
endmodule

// File: tb/cam_bridge_tb_top.sv
module cam_bridge_tb_top;
  localparam int unsigned RSTC = 20;
  localparam int unsigned TMO  = 16;

  typedef struct packed {
    logic       we;
    logic [1:0] sel;
    logic [7:0] wd;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  // R1 address low, R2 address high, R5/R4 bus control
  localparam vec_t VEC [8] = '{
    '{1'b1, 2'd0, 8'hAB, 8'h00, 4'd1},
    '{1'b0, 2'd0, 8'h00, 8'hAA, 4'd1},
    '{1'b1, 2'd1, 8'hFF, 8'h00, 4'd2},
    '{1'b0, 2'd1, 8'h00, 8'h7F, 4'd2},
    '{1'b1, 2'd2, 8'hCC, 8'h00, 4'd5},
    '{1'b0, 2'd2, 8'h00, 8'hCF, 4'd5},
    '{1'b1, 2'd2, 8'h00, 8'h00, 4'd4},
    '{1'b0, 2'd2, 8'h00, 8'h03, 4'd4}
  };

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [1:0] sel = 0;
  logic [7:0] wd = 0;
  logic ack;
  logic [7:0] rdata;
  logic [13:0] caddr;
  logic [1:0] cs, creset, ts_en;
  logic space, rd, wr, ready, ev;
  logic [7:0] cwd, crd;
  logic [1:0] pres_n = 2'b11;
  logic ready_en = 1;

  int total = 0, bad = 0;
  int rst0_cnt = 0, rst1_cnt = 0, ev_cnt = 0;
  logic [1:0] seen_cs;
  logic seen_space;
  logic [13:0] seen_addr;
  logic [7:0] seen_wd;

  always #2 clk = ~clk;

  cam_bridge #(.RST_CYCLES(RSTC), .TIMEOUT(TMO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(req), .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wd),
    .reg_ack_o(ack), .reg_rdata_o(rdata),
    .card_addr_o(caddr), .card_cs_o(cs), .card_space_o(space),
    .card_rd_o(rd), .card_wr_o(wr), .card_wdata_o(cwd),
    .card_rdata_i(crd), .card_ready_i(ready),
    .card_reset_o(creset), .ts_en_o(ts_en),
    .card_present_ni(pres_n), .event_o(ev)
  );

  function automatic logic [7:0] card_byte(logic [13:0] a, logic [1:0] c, logic sp);
    return a[7:0] ^ 8'h5A ^ (c[1] ? 8'h0F : 8'h00) ^ (sp ? 8'hF0 : 8'h00);
  endfunction

  assign ready = (rd | wr) & ready_en;
  assign crd   = card_byte(caddr, cs, space);

  always @(negedge clk) begin
    if (creset[0]) rst0_cnt++;
    if (creset[1]) rst1_cnt++;
    if (ev) ev_cnt++;
    if (rd | wr) begin
      seen_cs = cs; seen_space = space; seen_addr = caddr; seen_wd = cwd;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [1:0] s, input logic [7:0] d,
                     output logic [7:0] rv, output int n);
    @(negedge clk);
    req = 1; we = w; sel = s; wd = d;
    @(posedge clk);
    @(negedge clk);
    req = 0;
    n = 1;
    while (!ack && n < 200) begin
      @(posedge clk); @(negedge clk); n++;
    end
    rv = rdata;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 outputs", {creset, ts_en, cs, rd, wr, ev, ack}, 0);
    chk("R12 addr", caddr, 0);
    acc(0, 2'd2, 0, v, n);
    chk("R12 ctrl", v, 8'h03);

    // table walk; every register access acked in one cycle (R11)
    foreach (VEC[i]) begin
      acc(VEC[i].we, VEC[i].sel, VEC[i].wd, v, n);
      chk($sformatf("R11 ack vec%0d", i), n, 1);
      if (!VEC[i].we) chk($sformatf("R%0d vec%0d", VEC[i].req, i), v, VEC[i].exp);
    end
    chk("R4 no reset from zero write", rst0_cnt + rst1_cnt, 0);

    // R5 path enables, slot order reversed in the field
    acc(1, 2'd2, 8'h08, v, n);
    chk("R5 slot0 ts", ts_en, 2'b01);
    acc(1, 2'd2, 8'h04, v, n);
    chk("R5 slot1 ts", ts_en, 2'b10);

    // R7 read, control space, slot 0
    acc(1, 2'd0, 8'h2A, v, n);
    acc(1, 2'd1, 8'hA2, v, n);
    chk("R2 card addr", caddr, {7'h22, 7'h15});
    acc(1, 2'd2, 8'h40, v, n);
    acc(0, 2'd3, 0, v, n);
    chk("R7 read ack cycles", n, 2);
    chk("R7 read byte", v, card_byte({7'h22, 7'h15}, 2'b01, 1'b1));
    chk("R3 cs slot0", seen_cs, 2'b01);
    chk("R3 space ctl", seen_space, 1'b1);
    chk("R1 addr at card", seen_addr, 14'h1115);

    // R3 slot 1 attribute memory
    acc(1, 2'd2, 8'h80, v, n);
    acc(0, 2'd3, 0, v, n);
    chk("R3 cs slot1", seen_cs, 2'b10);
    chk("R3 space attr", seen_space, 1'b0);
    chk("R7 read slot1", v, card_byte(14'h1115, 2'b10, 1'b0));

    // R8 write
    acc(1, 2'd3, 8'h3C, v, n);
    chk("R8 write data", seen_wd, 8'h3C);
    chk("R8 write addr", seen_addr, 14'h1115);
    chk("R8 strobes idle", {rd, wr}, 2'b00);

    // R9 timeout
    ready_en = 0;
    acc(0, 2'd3, 0, v, n);
    chk("R9 timeout cycles", n, TMO + 1);
    chk("R9 timeout byte", v, 8'hFF);
    chk("R9 strobe dropped", {rd, wr}, 2'b00);
    ready_en = 1;

    // R4 reset pulse slot 0
    rst0_cnt = 0; rst1_cnt = 0;
    acc(1, 2'd2, 8'h20, v, n);
    acc(0, 2'd2, 0, v, n);
    chk("R4 busy bit set", v[5], 1'b1);
    repeat (RSTC + 10) @(negedge clk);
    chk("R4 slot0 pulse length", rst0_cnt, RSTC);
    chk("R4 slot1 untouched", rst1_cnt, 0);
    acc(0, 2'd2, 0, v, n);
    chk("R4 bit cleared", v[5:4], 2'b00);
    rst0_cnt = 0;
    acc(1, 2'd2, 8'h10, v, n);
    repeat (RSTC + 10) @(negedge clk);
    chk("R4 slot1 pulse length", rst1_cnt, RSTC);
    chk("R4 slot0 untouched", rst0_cnt, 0);

    // R6 / R10 presence
    ev_cnt = 0;
    @(negedge clk) pres_n = 2'b10;
    repeat (5) @(negedge clk);
    chk("R10 one event", ev_cnt, 1);
    acc(0, 2'd2, 0, v, n);
    chk("R6 slot0 present", v[1:0], 2'b01);
    ev_cnt = 0;
    @(negedge clk) pres_n = 2'b01;
    repeat (5) @(negedge clk);
    chk("R10 second event", ev_cnt, 1);
    acc(0, 2'd2, 0, v, n);
    chk("R6 slot1 present", v[1:0], 2'b10);
    ev_cnt = 0;
    repeat (5) @(negedge clk);
    chk("R10 quiet when stable", ev_cnt, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule